// File: doc/BRIEF.md
# Epoch-Based Crossbar Allocator

This block schedules a switched backplane that joins `N_CARDS` cards (15 by default) through a crossbar. Time is divided into epochs of `EPOCH_CYCLES` allocator cycles (8 by default). Once per epoch the block takes three inputs: a snapshot of which source cards want to reach which destination cards, a per-destination inhibit vector used for flow control, and a flag per card that marks forwarding-engine sources. From these it builds a conflict-free set of source/destination pairings. The result is registered, held for a whole epoch, and announced with one-cycle configure strobes to every source and destination card that takes part.

The matching is greedy and is walked along the diagonals of a permuted request matrix. A diagonal never repeats a source or a destination, so every candidate on it can be checked in parallel. The first pass admits only forwarding-engine sources. The second pass admits all sources. Every epoch a free-running LFSR picks a fresh permutation for the source order and another for the destination order, each made of a rotation and a fixed index-remapping pattern. This removes any standing bias toward low-numbered cards. The pipeline has three stages: requests are captured at an epoch boundary, the allocation runs during the next epoch, and the grants appear at the boundary after that.

Top module: `xbar_alloc`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it is released, `grant_o`, `epoch_o`, `src_cfg_o` and `dst_cfg_o` are all zero.
- R2: `epoch_o` pulses for exactly one cycle every `EPOCH_CYCLES` cycles, and `grant_o` changes only in a cycle where `epoch_o` is high.
- R3: The request, inhibit and forwarding-engine inputs present at the clock edge that raises `epoch_o` are the ones whose allocation is shown at the next `epoch_o` pulse.
- R4: A grant is given only for a pair that was requested.
- R5: No grant targets a destination whose inhibit bit was set in the captured snapshot.
- R6: Each source and each destination appears in at most one grant per epoch.
- R7: The matching is maximal. No requested, non-inhibited pair is left where both its source and its destination are ungranted.
- R8: Forwarding-engine priority. For every requested, non-inhibited pair from a source with `fe_i` set, either that source is granted, or its destination is granted to another forwarding-engine source.
- R9: While `epoch_o` is high, `src_cfg_o[i]` is high exactly when source i holds a grant, and `dst_cfg_o[j]` is high exactly when destination j holds a grant. Both strobes are zero in every other cycle.
- R10: When two sources compete over many epochs for a single destination and request nothing else, each of them wins at least once.
- R11: Bit `i*N_CARDS + j` of `req_i` and of `grant_o` stands for the pair source i to destination j. Bit j of `inhibit_i` refers to destination j, and bit i of `fe_i` refers to source i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Allocator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_CARDS*N_CARDS | Request matrix, bit i*N_CARDS+j = source i to destination j |
| inhibit_i | input | N_CARDS | Per-destination flow-control inhibit |
| fe_i | input | N_CARDS | Source is a forwarding engine |
| grant_o | output | N_CARDS*N_CARDS | Grant matrix, same layout as req_i, held for an epoch |
| epoch_o | output | 1 | One-cycle pulse when a new grant matrix appears |
| src_cfg_o | output | N_CARDS | Source configure strobes, valid with epoch_o |
| dst_cfg_o | output | N_CARDS | Destination configure strobes, valid with epoch_o |

## Verification
The matching is tried with several input patterns, each chosen to expose a different fault:
- A lone request exposes pipeline latency errors, since the grant must land exactly two epochs after it is driven.
- A full permutation has exactly one maximal matching, so any missed candidate on a diagonal shows up.
- An all-ones matrix tests the same thing at full load.
- Matrices with some or all columns inhibited separate flow-control masking from matching.
- A forwarding-engine source and a line card contending for one destination expose a broken pass order.
- Two line cards contending over many epochs show whether the permutation really changes who wins.
- Random sparse matrices with random inhibit and engine flags are checked for legality, maximality and priority in every epoch.

// File: rtl/xbar_alloc_pkg.sv
`timescale 1ns/1ps
package xbar_alloc_pkg;

  typedef enum logic [1:0] {
    PERM_ID     = 2'd0,
    PERM_REV    = 2'd1,
    PERM_MIR    = 2'd2,
    PERM_MIRREV = 2'd3
  } perm_e;

  function automatic int unsigned bit_rev(input int unsigned k, input int unsigned w);
    int unsigned r;
    r = 0;
    for (int unsigned b = 0; b < w; b++)
      if (((k >> b) & 32'd1) != 0) r = r | (32'd1 << (w - 1 - b));
    return r;
  endfunction

endpackage

// File: rtl/xb_lfsr.sv
`timescale 1ns/1ps
module xb_lfsr #(
  parameter int unsigned   W    = 16,
  parameter logic [W-1:0]  TAPS = 16'hB400,
  parameter logic [W-1:0]  SEED = 16'hACE1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] state_o
);
  logic [W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= SEED;
    else         st_q <= (st_q >> 1) ^ (st_q[0] ? TAPS : '0);
  end

  assign state_o = st_q;
endmodule

// File: rtl/xb_perm.sv
`timescale 1ns/1ps
module xb_perm
  import xbar_alloc_pkg::*;
#(
  parameter  int unsigned N = 15,
  localparam int unsigned W = $clog2(N)
) (
  input  logic [W-1:0]        rot_i,
  input  perm_e               sel_i,
  output logic [N-1:0][W-1:0] map_o
);
  // bit reversal is a bijection only when N fills the index space
  localparam bit REV_OK = ((2 ** W) == N) || ((2 ** W) - 1 == N);

  for (genvar k = 0; k < N; k++) begin : g_slot
    localparam int unsigned B_ID  = k;
    localparam int unsigned B_REV = REV_OK ? bit_rev(k, W) : k;
    localparam int unsigned B_MIR = N - 1 - k;
    localparam int unsigned B_MR  = N - 1 - B_REV;
    logic [W-1:0] base;
    logic [W:0]   sum;
    always_comb begin
      unique case (sel_i)
        PERM_ID:     base = W'(B_ID);
        PERM_REV:    base = W'(B_REV);
        PERM_MIR:    base = W'(B_MIR);
        PERM_MIRREV: base = W'(B_MR);
        default:     base = W'(B_ID);
      endcase
      sum = {1'b0, base} + {1'b0, rot_i};
      map_o[k] = (sum >= (W+1)'(N)) ? W'(sum - (W+1)'(N)) : sum[W-1:0];
    end
  end
endmodule

// File: rtl/xb_diag_step.sv
`timescale 1ns/1ps
module xb_diag_step #(
  parameter  int unsigned N = 15,
  localparam int unsigned W = $clog2(N)
) (
  input  logic [N-1:0][N-1:0] legal_i,
  input  logic [N-1:0]        fe_i,
  input  logic                en_i,
  input  logic                fe_only_i,
  input  logic [W-1:0]        diag_i,
  input  logic [N-1:0][W-1:0] smap_i,
  input  logic [N-1:0][W-1:0] dmap_i,
  input  logic [N-1:0]        sbusy_i,
  input  logic [N-1:0]        dbusy_i,
  input  logic [N-1:0][N-1:0] grant_i,
  output logic [N-1:0]        sbusy_o,
  output logic [N-1:0]        dbusy_o,
  output logic [N-1:0][N-1:0] grant_o
);
  logic [N-1:0][W-1:0] src_c, dst_c;
  logic [N-1:0]        hit;

  // slots on one diagonal share no source and no destination
  for (genvar s = 0; s < N; s++) begin : g_pair
    logic [W:0]   tsum;
    logic [W-1:0] t;
    assign tsum     = (W+1)'(s) + {1'b0, diag_i};
    assign t        = (tsum >= (W+1)'(N)) ? W'(tsum - (W+1)'(N)) : tsum[W-1:0];
    assign src_c[s] = smap_i[s];
    assign dst_c[s] = dmap_i[t];
    assign hit[s]   = en_i & legal_i[src_c[s]][dst_c[s]]
                    & (~fe_only_i | fe_i[src_c[s]])
                    & ~sbusy_i[src_c[s]] & ~dbusy_i[dst_c[s]];
  end

  always_comb begin
    sbusy_o = sbusy_i;
    dbusy_o = dbusy_i;
    grant_o = grant_i;
    for (int s = 0; s < N; s++) begin
      if (hit[s]) begin
        sbusy_o[src_c[s]]           = 1'b1;
        dbusy_o[dst_c[s]]           = 1'b1;
        grant_o[src_c[s]][dst_c[s]] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/xbar_alloc.sv
`timescale 1ns/1ps
module xbar_alloc
  import xbar_alloc_pkg::*;
#(
  parameter int unsigned N_CARDS      = 15,
  parameter int unsigned EPOCH_CYCLES = 8,
  parameter logic [15:0] LFSR_SEED    = 16'hACE1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [N_CARDS*N_CARDS-1:0]   req_i,
  input  logic [N_CARDS-1:0]           inhibit_i,
  input  logic [N_CARDS-1:0]           fe_i,
  output logic [N_CARDS*N_CARDS-1:0]   grant_o,
  output logic                         epoch_o,
  output logic [N_CARDS-1:0]           src_cfg_o,
  output logic [N_CARDS-1:0]           dst_cfg_o
);
  localparam int unsigned N     = N_CARDS;
  localparam int unsigned W     = $clog2(N);
  localparam int unsigned CW    = (EPOCH_CYCLES > 1) ? $clog2(EPOCH_CYCLES) : 1;
  localparam int unsigned STEPS = 2 * N;  // engine pass then open pass
  localparam int unsigned SPC   = (STEPS + EPOCH_CYCLES - 1) / EPOCH_CYCLES;
  localparam int unsigned SW    = $clog2(SPC * EPOCH_CYCLES + 1);

  logic [CW-1:0]        cyc_q;
  logic                 last_c;
  logic [N-1:0][N-1:0]  legal_q, req_m, grant_q;
  logic [N-1:0]         fe_q;
  logic [W-1:0]         srot_q, drot_q;
  perm_e                ssel_q, dsel_q;
  logic [N-1:0]         wsb_q, wdb_q;
  logic [N-1:0][N-1:0]  wg_q;
  logic                 epoch_q;
  logic [N-1:0]         scfg_q, dcfg_q;
  logic [15:0]          lfsr;
  logic [N-1:0][W-1:0]  smap, dmap;

  logic [SPC:0][N-1:0]        sb_ch, db_ch;
  logic [SPC:0][N-1:0][N-1:0] g_ch;
  logic [N-1:0]               row_any, col_any;
  logic [W-1:0]               srot_n, drot_n;

  assign last_c = (cyc_q == CW'(EPOCH_CYCLES - 1));
  assign req_m  = req_i;

  xb_lfsr #(.W(16), .TAPS(16'hB400), .SEED(LFSR_SEED)) u_lfsr (
    .clk_i(clk_i), .rst_ni(rst_ni), .state_o(lfsr)
  );

  always_comb begin
    srot_n = (lfsr[W-1:0] >= W'(N)) ? W'(lfsr[W-1:0] - W'(N)) : lfsr[W-1:0];
    drot_n = (lfsr[2*W+1:W+2] >= W'(N)) ? W'(lfsr[2*W+1:W+2] - W'(N)) : lfsr[2*W+1:W+2];
  end

  xb_perm #(.N(N)) u_sperm (.rot_i(srot_q), .sel_i(ssel_q), .map_o(smap));
  xb_perm #(.N(N)) u_dperm (.rot_i(drot_q), .sel_i(dsel_q), .map_o(dmap));

  assign sb_ch[0] = wsb_q;
  assign db_ch[0] = wdb_q;
  assign g_ch[0]  = wg_q;

  for (genvar k = 0; k < SPC; k++) begin : g_step
    logic [SW-1:0] st;
    logic          en, fe_only;
    logic [W-1:0]  diag;
    always_comb begin
      st      = SW'(cyc_q) * SW'(SPC) + SW'(k);
      en      = (st < SW'(STEPS));
      fe_only = (st < SW'(N));
      if (!en)          diag = '0;
      else if (fe_only) diag = W'(st);
      else              diag = W'(st - SW'(N));
    end
    xb_diag_step #(.N(N)) u_step (
      .legal_i(legal_q), .fe_i(fe_q), .en_i(en), .fe_only_i(fe_only),
      .diag_i(diag), .smap_i(smap), .dmap_i(dmap),
      .sbusy_i(sb_ch[k]), .dbusy_i(db_ch[k]), .grant_i(g_ch[k]),
      .sbusy_o(sb_ch[k+1]), .dbusy_o(db_ch[k+1]), .grant_o(g_ch[k+1])
    );
  end

  always_comb begin
    col_any = '0;
    for (int i = 0; i < N; i++) begin
      row_any[i] = |g_ch[SPC][i];
      col_any    = col_any | g_ch[SPC][i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q   <= '0;
      legal_q <= '0;
      fe_q    <= '0;
      srot_q  <= '0;
      drot_q  <= '0;
      ssel_q  <= PERM_ID;
      dsel_q  <= PERM_ID;
      wsb_q   <= '0;
      wdb_q   <= '0;
      wg_q    <= '0;
      grant_q <= '0;
      epoch_q <= 1'b0;
      scfg_q  <= '0;
      dcfg_q  <= '0;
    end else if (last_c) begin
      cyc_q   <= '0;
      grant_q <= g_ch[SPC];
      epoch_q <= 1'b1;
      scfg_q  <= row_any;
      dcfg_q  <= col_any;
      wsb_q   <= '0;
      wdb_q   <= '0;
      wg_q    <= '0;
      for (int i = 0; i < N; i++) legal_q[i] <= req_m[i] & ~inhibit_i;
      fe_q    <= fe_i;
      srot_q  <= srot_n;
      drot_q  <= drot_n;
      ssel_q  <= perm_e'(lfsr[W+1:W]);
      dsel_q  <= perm_e'(lfsr[2*W+3:2*W+2]);
    end else begin
      cyc_q   <= cyc_q + CW'(1);
      wsb_q   <= sb_ch[SPC];
      wdb_q   <= db_ch[SPC];
      wg_q    <= g_ch[SPC];
      epoch_q <= 1'b0;
      scfg_q  <= '0;
      dcfg_q  <= '0;
    end
  end

  assign grant_o   = grant_q;
  assign epoch_o   = epoch_q;
  assign src_cfg_o = scfg_q;
  assign dst_cfg_o = dcfg_q;
endmodule

// File: rtl/xbar_alloc_chk.sv
`timescale 1ns/1ps
module xbar_alloc_chk #(
  parameter int unsigned N_CARDS      = 15,
  parameter int unsigned EPOCH_CYCLES = 8
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [N_CARDS*N_CARDS-1:0] req_i,
  input logic [N_CARDS-1:0]         inhibit_i,
  input logic [N_CARDS*N_CARDS-1:0] grant_o,
  input logic                       epoch_o,
  input logic [N_CARDS-1:0]         src_cfg_o,
  input logic [N_CARDS-1:0]         dst_cfg_o
);
  localparam int unsigned N  = N_CARDS;
  localparam int unsigned CW = (EPOCH_CYCLES > 1) ? $clog2(EPOCH_CYCLES) : 1;

  logic [CW-1:0]              cnt_q;
  logic                       wrapped_q;
  logic [N*N-1:0]             req_snap_q, req_use_q;
  logic [N-1:0]               inh_snap_q, inh_use_q;
  logic [N-1:0][N-1:0]        gm;
  logic [N-1:0][N-1:0]        gt;
  logic [N-1:0]               col_used;

  assign gm = grant_o;
  always_comb begin
    col_used = '0;
    for (int i = 0; i < N; i++) begin
      col_used = col_used | gm[i];
      for (int j = 0; j < N; j++) gt[j][i] = gm[i][j];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      wrapped_q  <= 1'b0;
      req_snap_q <= '0;
      req_use_q  <= '0;
      inh_snap_q <= '0;
      inh_use_q  <= '0;
    end else if (cnt_q == CW'(EPOCH_CYCLES - 1)) begin
      cnt_q      <= '0;
      wrapped_q  <= 1'b1;
      req_use_q  <= req_snap_q;
      req_snap_q <= req_i;
      inh_use_q  <= inh_snap_q;
      inh_snap_q <= inhibit_i;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  // R2
  epoch_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |-> (epoch_o == (wrapped_q && cnt_q == '0)));

  // R2
  grant_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !epoch_o |-> $stable(grant_o));

  // R4
  only_requested_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |-> ((grant_o & ~req_use_q) == '0));

  // R5
  inhibit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |-> ((col_used & inh_use_q) == '0));

  for (genvar k = 0; k < N; k++) begin : g_k
    // R6
    src_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |-> $onehot0(gm[k]));
    // R6
    dst_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |-> $onehot0(gt[k]));
    // R9
    src_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |-> (src_cfg_o[k] == (epoch_o && (|gm[k]))));
    // R9
    dst_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |-> (dst_cfg_o[k] == (epoch_o && col_used[k])));
  end
endmodule

bind xbar_alloc xbar_alloc_chk #(.N_CARDS(N_CARDS), .EPOCH_CYCLES(EPOCH_CYCLES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .inhibit_i(inhibit_i),
  .grant_o(grant_o), .epoch_o(epoch_o), .src_cfg_o(src_cfg_o), .dst_cfg_o(dst_cfg_o)
);

// File: tb/xbar_alloc_test.sv
`timescale 1ns/1ps
module xbar_alloc_test;
  localparam int N  = 15;
  localparam int NN = N * N;
  localparam int EP = 8;
  localparam int FA = 3, FB = 9, FD = 5;

  typedef struct {
    logic [NN-1:0] req;
    logic [N-1:0]  inh;
    logic [N-1:0]  fe;
    int            exp_cnt;
    bit            fair;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NN-1:0] req = '0;
  logic [N-1:0]  inh = '0;
  logic [N-1:0]  fe  = '0;
  logic [NN-1:0] grant;
  logic          epoch;
  logic [N-1:0]  scfg, dcfg;

  int n_cmp = 0, n_bad = 0;
  int wins_a = 0, wins_b = 0;
  int cyc_cnt = 0, last_ep = -1;
  item_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc_cnt++;

  xbar_alloc uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .inhibit_i(inh), .fe_i(fe),
    .grant_o(grant), .epoch_o(epoch), .src_cfg_o(scfg), .dst_cfg_o(dcfg)
  );

  task automatic chk(input bit ok, input string r, input logic [255:0] act, input logic [255:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic drive(input logic [NN-1:0] r, input logic [N-1:0] ih, input logic [N-1:0] f,
                       input int ec, input bit fr);
    item_t it;
    do @(negedge clk); while (!epoch);
    req = r; inh = ih; fe = f;
    it.req = r; it.inh = ih; it.fe = f; it.exp_cnt = ec; it.fair = fr;
    q.push_back(it);
  endtask

  task automatic check_epoch(input item_t it);
    logic [N-1:0] row_used, col_used, col_fe;
    int multi, unblocked, fe_lost, cnt;
    row_used = '0; col_used = '0; col_fe = '0;
    multi = 0; unblocked = 0; fe_lost = 0; cnt = 0;
    for (int i = 0; i < N; i++) begin
      int rc;
      rc = 0;
      for (int j = 0; j < N; j++) if (grant[i*N+j]) begin
        rc++; cnt++;
        row_used[i] = 1'b1;
        if (col_used[j]) multi++;
        col_used[j] = 1'b1;
        if (it.fe[i]) col_fe[j] = 1'b1;
      end
      if (rc > 1) multi++;
    end
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (it.req[i*N+j] && !it.inh[j]) begin
          if (!row_used[i] && !col_used[j]) unblocked++;
          if (it.fe[i] && !row_used[i] && !col_fe[j]) fe_lost++;
        end
    // R4 and R11: grants only on requested bits
    chk((grant & ~it.req) == '0, "R4 grant outside request", 256'(grant & ~it.req), 0);
    chk((col_used & it.inh) == '0, "R5 inhibited destination granted", 256'(col_used & it.inh), 0);
    chk(multi == 0, "R6 source/destination reused", 256'(multi), 0);
    chk(unblocked == 0, "R7 matching not maximal", 256'(unblocked), 0);
    chk(fe_lost == 0, "R8 forwarding-engine request lost", 256'(fe_lost), 0);
    chk(scfg == row_used, "R9 source strobes", 256'(scfg), 256'(row_used));
    chk(dcfg == col_used, "R9 destination strobes", 256'(dcfg), 256'(col_used));
    if (it.exp_cnt >= 0)
      chk(cnt == it.exp_cnt, "R3 grant count for this epoch's snapshot", 256'(cnt), 256'(it.exp_cnt));
    if (it.fair) begin
      if (grant[FA*N+FD]) wins_a++;
      if (grant[FB*N+FD]) wins_b++;
    end
  endtask

  // monitor
  initial begin
    item_t it;
    logic [NN-1:0] g_prev;
    forever begin
      @(negedge clk);
      if (rst_n && epoch) begin
        if (last_ep >= 0)
          chk(cyc_cnt - last_ep == EP, "R2 epoch spacing", 256'(cyc_cnt - last_ep), 256'(EP));
        last_ep = cyc_cnt;
        if (q.size() == 0) chk(1'b0, "R3 result with no expected item", 256'(grant), 0);
        else begin
          it = q.pop_front();
          check_epoch(it);
        end
        g_prev = grant;
        @(negedge clk);
        chk(epoch == 1'b0, "R2 epoch pulse width", 256'(epoch), 0);
        chk(grant == g_prev, "R2 grant held", 256'(grant), 256'(g_prev));
        chk(scfg == '0 && dcfg == '0, "R9 strobes cleared", 256'({scfg, dcfg}), 0);
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    item_t z;
    logic [NN-1:0] r;
    logic [N-1:0]  ih, f;
    z.req = '0; z.inh = '0; z.fe = '0; z.exp_cnt = 0; z.fair = 1'b0;
    q.push_back(z);
    q.push_back(z);
    repeat (3) @(negedge clk);
    chk(grant == '0 && epoch == 1'b0 && scfg == '0 && dcfg == '0, "R1 state in reset",
        256'(grant), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(grant == '0 && epoch == 1'b0 && scfg == '0 && dcfg == '0, "R1 state after release",
        256'(grant), 0);

    // R3: lone request
    r = '0; r[3*N+7] = 1'b1;
    drive(r, '0, '0, 1, 1'b0);
    // R7: full permutation i -> 2i mod N, unique maximal matching
    r = '0;
    for (int i = 0; i < N; i++) r[i*N + ((2*i) % N)] = 1'b1;
    drive(r, '0, '0, N, 1'b0);
    drive(r, '0, '0, N, 1'b0);
    // R5: every destination inhibited
    drive('1, '1, '0, 0, 1'b0);
    // R7: all requests, nothing inhibited
    drive('1, '0, '0, N, 1'b0);
    // R5: five low destinations inhibited
    drive('1, 15'h001F, '0, N - 5, 1'b0);
    // R8: engine source 2 and line card 7 want destination 4
    for (int e = 0; e < 6; e++) begin
      r = '0; r[2*N+4] = 1'b1; r[7*N+4] = 1'b1;
      f = '0; f[2] = 1'b1;
      drive(r, '0, f, 1, 1'b0);
    end
    // R8: engines and line cards over a dense matrix
    f = 15'h0421;
    drive('1, '0, f, N, 1'b0);
    // R10: two line cards on one destination
    for (int e = 0; e < 24; e++) begin
      r = '0; r[FA*N+FD] = 1'b1; r[FB*N+FD] = 1'b1;
      drive(r, '0, '0, 1, 1'b1);
    end
    // random sparse patterns
    for (int e = 0; e < 20; e++) begin
      for (int b = 0; b < NN; b++) r[b] = (($urandom % 5) == 0);
      for (int b = 0; b < N; b++) begin
        ih[b] = (($urandom % 6) == 0);
        f[b]  = (($urandom % 4) == 0);
      end
      drive(r, ih, f, -1, 1'b0);
    end
    drive('0, '0, '0, 0, 1'b0);
    drive('0, '0, '0, 0, 1'b0);
    @(negedge clk);
    @(negedge clk);
    chk(wins_a > 0, "R10 first contender never won", 256'(wins_a), 1);
    chk(wins_b > 0, "R10 second contender never won", 256'(wins_b), 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule